// File: doc/BRIEF.md
# Permuted Bank Mapper with Row-Buffer Tracking

This block sits at the front of a DRAM controller and handles one memory request at a time. It splits a physical address into a row index, a bank index and a column offset. The bank index does not come straight from the bank field. It is that field XORed with a group of low cache-tag bits. As a result, addresses that fight over the same cache set land in different banks, while bytes inside one page keep their order.

The block keeps a small table with one entry per bank. Each entry records whether the bank's row buffer is open and which row it holds. On every accepted request the block compares the request with the table entry for its bank and assigns one of three classes:

- a row hit,
- a miss on a precharged (closed) bank,
- a conflict with another open row.

It then steps through the DRAM command sequence for that class and pulses `done` once the class latency, counted in clock cycles, has elapsed. Rows are left open after each access (open-page policy).

Top module: `xor_bank_mapper`

## Requirements
- R1: The column offset output equals address bits [10:0] unchanged, and the row output equals address bits [31:16]. Both are captured when the request is accepted and held until the next acceptance.
- R2: The bank output equals address bits [15:11] XOR address bits [23:19]. Two addresses that agree in bits [18:0] but differ in bits [23:19] get different banks. 32 consecutive 2 KB pages whose bits [23:19] do not change cover all 32 banks.
- R3: After reset, `req_ready`=1, `done`=0, `cmd`=0 (no operation), and every bank is closed, so the first access to any bank is classed as a closed miss.
- R4: A request to a bank whose open row equals the requested row is classed 0 (hit). It issues only a column command, in the first cycle after acceptance, and `done` rises HIT_CYC (default 4) cycles after acceptance.
- R5: A request to a closed bank is classed 1. It issues an activate (code 2) in the first cycle, then a column command MISS_CYC-HIT_CYC cycles later, and `done` rises MISS_CYC (default 8) cycles after acceptance.
- R6: A request to a bank holding a different open row is classed 2. It issues a precharge (code 1) in the first cycle, an activate CONF_CYC-MISS_CYC cycles later, and a column command CONF_CYC-HIT_CYC cycles after the first cycle. `done` rises CONF_CYC (default 14) cycles after acceptance.
- R7: After any access, the bank holds the accessed row open. A later request to the same row of that bank is a hit.
- R8: From the acceptance cycle until the `done` cycle, `req_ready` is 0. Requests presented while ready is low are ignored: no command is issued for them and no access starts afterwards.
- R9: `done` is high for exactly one cycle per request, and `req_ready` is high in that cycle.
- R10: The column command is code 3 for a read (`req_write`=0) and code 4 for a write (`req_write`=1). Cycles without a command show code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_addr | input | 32 | Physical byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| map_bank | output | 5 | Permuted bank index of the current request |
| map_row | output | 16 | Row (page) index of the current request |
| map_col | output | 11 | Column offset within the page |
| acc_class | output | 2 | 0 hit, 1 closed miss, 2 row conflict |
| cmd | output | 3 | 0 none, 1 precharge, 2 activate, 3 read column, 4 write column |
| done | output | 1 | One-cycle pulse when the access latency has elapsed |

## Verification
The assertions take for granted that a request counts only in a cycle where both valid and ready are high. They also rely on the hit latency being at least two cycles, so one access never produces back-to-back done pulses. The bench raises valid only when ready is high and drops it in the done cycle. The exception is one deliberate case that keeps valid high with a different address while the block is busy. In that case valid is still released before the done cycle, so the extra request is never taken and its effect on the outputs can be checked.

// File: rtl/xbm_pkg.sv
package xbm_pkg;

   typedef enum logic [1:0] {
      ACC_HIT      = 2'd0,
      ACC_CLOSED   = 2'd1,
      ACC_CONFLICT = 2'd2
   } acc_class_e;

   typedef enum logic [2:0] {
      CMD_NOP = 3'd0,
      CMD_PRE = 3'd1,
      CMD_ACT = 3'd2,
      CMD_RD  = 3'd3,
      CMD_WR  = 3'd4
   } dram_cmd_e;

endpackage

// File: rtl/xbm_addr_map.sv
module xbm_addr_map #(
   parameter int ADDR_W  = 32,
   parameter int COL_W   = 11,
   parameter int BANK_W  = 5,
   parameter int TAG_LSB = 19,
   parameter bit PERMUTE = 1'b1,
   localparam int ROW_W  = ADDR_W - COL_W - BANK_W
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [BANK_W-1:0] bank,
   output logic [ROW_W-1:0]  row,
   output logic [COL_W-1:0]  col
);
   logic [BANK_W-1:0] raw_bank;

   assign col      = addr[COL_W-1:0];
   assign raw_bank = addr[COL_W +: BANK_W];
   assign row      = addr[ADDR_W-1 -: ROW_W];

   generate
      if (PERMUTE) begin : g_xor
         assign bank = raw_bank ^ addr[TAG_LSB +: BANK_W];
      end else begin : g_plain
         assign bank = raw_bank;
      end
   endgenerate
endmodule

// File: rtl/xbm_row_table.sv
module xbm_row_table
   import xbm_pkg::*;
#(
   parameter int BANK_W = 5,
   parameter int ROW_W  = 16,
   localparam int NUM_BANKS = 1 << BANK_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BANK_W-1:0] lk_bank,
   input  logic [ROW_W-1:0]  lk_row,
   output acc_class_e        lk_class,
   input  logic              pre_en,
   input  logic              act_en,
   input  logic [BANK_W-1:0] up_bank,
   input  logic [ROW_W-1:0]  up_row
);
   logic [NUM_BANKS-1:0] open_vec;
   logic [ROW_W-1:0]     row_arr [NUM_BANKS];

   generate
      for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
         logic             open_r;
         logic [ROW_W-1:0] row_r;
         logic             sel;

         assign sel = (up_bank == BANK_W'(g));

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               open_r <= 1'b0;
               row_r  <= '0;
            end else if (sel && act_en) begin
               open_r <= 1'b1;
               row_r  <= up_row;
            end else if (sel && pre_en) begin
               open_r <= 1'b0;
            end
         end

         assign open_vec[g] = open_r;
         assign row_arr[g]  = row_r;
      end
   endgenerate

   always_comb begin
      if (!open_vec[lk_bank])
         lk_class = ACC_CLOSED;
      else if (row_arr[lk_bank] == lk_row)
         lk_class = ACC_HIT;
      else
         lk_class = ACC_CONFLICT;
   end
endmodule

// File: rtl/xbm_seq.sv
module xbm_seq
   import xbm_pkg::*;
#(
   parameter int HIT_CYC  = 4,
   parameter int MISS_CYC = 8,
   parameter int CONF_CYC = 14,
   localparam int CNT_W   = $clog2(CONF_CYC + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  acc_class_e start_class,
   input  logic       start_write,
   output logic       busy,
   output logic       done,
   output dram_cmd_e  cmd
);
   logic             busy_q;
   logic [CNT_W-1:0] rem_q;
   acc_class_e       cls_q;
   logic             wr_q;
   logic [CNT_W-1:0] load_len;

   always_comb begin
      case (start_class)
         ACC_HIT:    load_len = CNT_W'(HIT_CYC);
         ACC_CLOSED: load_len = CNT_W'(MISS_CYC);
         default:    load_len = CNT_W'(CONF_CYC);
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         rem_q  <= '0;
         cls_q  <= ACC_HIT;
         wr_q   <= 1'b0;
      end else if (start) begin
         busy_q <= 1'b1;
         rem_q  <= load_len;
         cls_q  <= start_class;
         wr_q   <= start_write;
      end else if (busy_q) begin
         if (rem_q == CNT_W'(1))
            busy_q <= 1'b0;
         rem_q <= rem_q - CNT_W'(1);
      end
   end

   assign busy = busy_q;
   assign done = busy_q && (rem_q == CNT_W'(1));

   always_comb begin
      cmd = CMD_NOP;
      if (busy_q) begin
         if (cls_q == ACC_CONFLICT && rem_q == CNT_W'(CONF_CYC))
            cmd = CMD_PRE;
         else if (cls_q != ACC_HIT && rem_q == CNT_W'(MISS_CYC))
            cmd = CMD_ACT;
         else if (rem_q == CNT_W'(HIT_CYC))
            cmd = wr_q ? CMD_WR : CMD_RD;
      end
   end
endmodule

// File: rtl/xor_bank_mapper.sv
module xor_bank_mapper
   import xbm_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int COL_W    = 11,
   parameter int BANK_W   = 5,
   parameter int TAG_LSB  = 19,
   parameter bit PERMUTE  = 1'b1,
   parameter int HIT_CYC  = 4,
   parameter int MISS_CYC = 8,
   parameter int CONF_CYC = 14,
   localparam int ROW_W   = ADDR_W - COL_W - BANK_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   output logic [BANK_W-1:0] map_bank,
   output logic [ROW_W-1:0]  map_row,
   output logic [COL_W-1:0]  map_col,
   output logic [1:0]        acc_class,
   output logic [2:0]        cmd,
   output logic              done
);
   generate
      if (HIT_CYC < 2) begin : g_bad_hit
         $error("HIT_CYC must be at least 2");
      end
      if (MISS_CYC <= HIT_CYC || CONF_CYC <= MISS_CYC) begin : g_bad_order
         $error("latencies must rise strictly: HIT < MISS < CONF");
      end
      if (PERMUTE && TAG_LSB < COL_W + BANK_W) begin : g_bad_tag
         $error("tag bits for the XOR must lie above the bank field");
      end
      if (TAG_LSB + BANK_W > ADDR_W) begin : g_bad_width
         $error("tag bit group exceeds the address width");
      end
   endgenerate

   logic [BANK_W-1:0] in_bank;
   logic [ROW_W-1:0]  in_row;
   logic [COL_W-1:0]  in_col;
   acc_class_e        in_class;
   logic              start, busy, seq_done;
   dram_cmd_e         seq_cmd;

   logic [BANK_W-1:0] bank_q;
   logic [ROW_W-1:0]  row_q;
   logic [COL_W-1:0]  col_q;
   acc_class_e        cls_q;

   xbm_addr_map #(
      .ADDR_W(ADDR_W), .COL_W(COL_W), .BANK_W(BANK_W),
      .TAG_LSB(TAG_LSB), .PERMUTE(PERMUTE)
   ) u_map (
      .addr(req_addr), .bank(in_bank), .row(in_row), .col(in_col)
   );

   xbm_row_table #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_table (
      .clk(clk), .rst_n(rst_n),
      .lk_bank(in_bank), .lk_row(in_row), .lk_class(in_class),
      .pre_en(seq_cmd == CMD_PRE), .act_en(seq_cmd == CMD_ACT),
      .up_bank(bank_q), .up_row(row_q)
   );

   xbm_seq #(.HIT_CYC(HIT_CYC), .MISS_CYC(MISS_CYC), .CONF_CYC(CONF_CYC)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .start_class(in_class),
      .start_write(req_write), .busy(busy), .done(seq_done), .cmd(seq_cmd)
   );

   assign req_ready = !busy || seq_done;
   assign start     = req_valid && req_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bank_q <= '0;
         row_q  <= '0;
         col_q  <= '0;
         cls_q  <= ACC_HIT;
      end else if (start) begin
         bank_q <= in_bank;
         row_q  <= in_row;
         col_q  <= in_col;
         cls_q  <= in_class;
      end
   end

   assign map_bank  = bank_q;
   assign map_row   = row_q;
   assign map_col   = col_q;
   assign acc_class = cls_q;
   assign cmd       = seq_cmd;
   assign done      = seq_done;
endmodule

// File: rtl/xbm_chk.sv
module xbm_chk #(
   parameter int ADDR_W = 32,
   parameter int COL_W  = 11
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [ADDR_W-1:0] req_addr,
   input logic [COL_W-1:0]  map_col,
   input logic [1:0]        acc_class,
   input logic [2:0]        cmd,
   input logic              done
);
   // R1
   col_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> map_col == $past(req_addr[COL_W-1:0]));

   // R8
   busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> req_ready);

   // R6
   pre_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == 3'd1) |-> (acc_class == 2'd2));

   // R4
   act_not_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == 3'd2) |-> (acc_class != 2'd0));

   // R10
   cmd_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd <= 3'd4);
endmodule

bind xor_bank_mapper xbm_chk #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .req_addr(req_addr), .map_col(map_col), .acc_class(acc_class),
   .cmd(cmd), .done(done)
);

// File: tb/xor_bank_mapper_tb.sv
module xor_bank_mapper_tb;
   localparam int CLK_PERIOD = 10;
   localparam int HIT  = 4;
   localparam int MISS = 8;
   localparam int CONF = 14;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_addr = '0;
   logic        req_write = 1'b0;
   logic [4:0]  map_bank;
   logic [15:0] map_row;
   logic [10:0] map_col;
   logic [1:0]  acc_class;
   logic [2:0]  cmd;
   logic        done;

   int checks = 0;
   int fails  = 0;
   bit ref_open [32];
   int ref_row  [32];
   int last_bank;

   always #(CLK_PERIOD/2) clk = ~clk;

   xor_bank_mapper u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_write(req_write), .map_bank(map_bank),
      .map_row(map_row), .map_col(map_col), .acc_class(acc_class),
      .cmd(cmd), .done(done)
   );

   task automatic chk(input bit ok, input string r, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
      end
   endtask

   function automatic int exp_cmd(input int cls, input int k, input bit wr);
      int len = (cls == 0) ? HIT : (cls == 1) ? MISS : CONF;
      if (cls == 2 && k == 1) return 1;
      if (cls != 0 && k == len - MISS + 1) return 2;
      if (k == len - HIT + 1) return wr ? 4 : 3;
      return 0;
   endfunction

   // Starts and ends at a falling edge.
   task automatic run_req(input logic [31:0] a, input bit wr,
                          input bit junk, input logic [31:0] ja);
      int eb = int'(a[15:11] ^ a[23:19]);
      int er = int'(a[31:16]);
      int ec = int'(a[10:0]);
      int cls = !ref_open[eb] ? 1 : (ref_row[eb] == er ? 0 : 2);
      int len = (cls == 0) ? HIT : (cls == 1) ? MISS : CONF;
      string t = (cls == 0) ? "R4" : (cls == 1) ? "R5" : "R6";
      chk(req_ready == 1'b1, "R8 ready before request", int'(req_ready), 1);
      req_valid = 1'b1; req_addr = a; req_write = wr;
      for (int k = 1; k <= len; k++) begin
         @(negedge clk);
         if (k == 1) begin
            chk(int'(map_col) == ec, "R1 column", int'(map_col), ec);
            chk(int'(map_row) == er, "R1 row", int'(map_row), er);
            chk(int'(map_bank) == eb, "R2 bank", int'(map_bank), eb);
            chk(int'(acc_class) == cls, {t, " class"}, int'(acc_class), cls);
            last_bank = int'(map_bank);
         end
         chk(int'(cmd) == exp_cmd(cls, k, wr), {t, " R10 command"}, int'(cmd), exp_cmd(cls, k, wr));
         chk(done == (k == len), "R9 done timing", int'(done), int'(k == len));
         chk(req_ready == (k == len), "R8 ready while busy", int'(req_ready), int'(k == len));
         if (junk && k < len) begin
            req_valid = 1'b1; req_addr = ja; req_write = 1'b1;
         end else begin
            req_valid = 1'b0;
         end
      end
      ref_open[eb] = 1'b1;
      ref_row[eb]  = er;
      @(negedge clk);
      chk(cmd == 3'd0, "R8 idle after done", int'(cmd), 0);
      chk(done == 1'b0, "R9 single pulse", int'(done), 0);
      chk(req_ready == 1'b1, "R8 idle ready", int'(req_ready), 1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int b1;
      logic [31:0] seen;
      for (int i = 0; i < 32; i++) begin ref_open[i] = 1'b0; ref_row[i] = 0; end
      repeat (3) @(negedge clk);
      // R3: reset state
      chk(req_ready == 1'b1, "R3 ready", int'(req_ready), 1);
      chk(done == 1'b0, "R3 done", int'(done), 0);
      chk(cmd == 3'd0, "R3 cmd", int'(cmd), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1 && cmd == 3'd0, "R3 after release", int'(cmd), 0);

      // R3/R5: first touch of a bank is a closed miss
      run_req(32'h0012_3A5C, 1'b0, 1'b0, '0);
      // R7/R4: same row again is a hit (write)
      run_req(32'h0012_3B00, 1'b1, 1'b0, '0);
      // R6: other row, same permuted bank (bit 16 flips the row only)
      run_req(32'h0013_3A5C, 1'b0, 1'b0, '0);
      // R7: the new row stays open
      run_req(32'h0013_3800, 1'b0, 1'b0, '0);

      // R2: cache-conflicting pair lands in different banks
      run_req(32'h0000_1800, 1'b0, 1'b0, '0);
      b1 = last_bank;
      run_req(32'h0008_1800, 1'b0, 1'b0, '0);
      chk(b1 != last_bank, "R2 conflict pair banks differ", last_bank, b1 ^ 1);

      // R2: consecutive pages spread over every bank
      seen = '0;
      for (int p = 0; p < 32; p++) begin
         run_req(32'h0040_0000 + (p << 11), p[0], 1'b0, '0);
         seen[last_bank] = 1'b1;
      end
      chk(seen == 32'hFFFF_FFFF, "R2 all banks covered", $countones(seen), 32);

      // R8: request held while busy is ignored
      run_req(32'h0040_0040, 1'b0, 1'b1, 32'h0777_0000);
      repeat (2) begin
         @(negedge clk);
         chk(cmd == 3'd0 && done == 1'b0, "R8 ignored request started nothing", int'(cmd), 0);
      end

      // R6 then R4 with write column
      run_req(32'h0050_0000, 1'b1, 1'b0, '0);
      run_req(32'h0050_0004, 1'b1, 1'b0, '0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule